// File: doc/BRIEF.md
# Byte-Wide Indirect Memory Window

This block gives a host with only byte-wide register cycles a way to reach a 32-bit memory space. It has a small window of registers. Four of them hold the target address, one byte each. A fifth register, the data port, starts one byte transfer on a request/ready memory bus each time the host touches it.

A host write to the data port stores that byte at the assembled address. A host read of the data port fetches the byte from that address and returns it. The host sees `hst_wait` high until the memory side has answered.

The address bytes keep their values between transfers. A host that walks through memory therefore only rewrites the bytes that change, for example the second byte alone.

Top module: `byte_window_bridge`

## Requirements
- R1: After reset all four address bytes read as zero, `mem_addr` is zero, `mem_req` and `hst_wait` are low, and `hst_rdata` is zero.
- R2: A host write to offsets 0, 1, 2 or 3 loads address bits 7:0, 15:8, 23:16 or 31:24 respectively. A host read of those offsets returns the stored byte on `hst_rdata` one cycle after the strobe, with no wait.
- R3: The address bytes hold their values across data-port transfers. Rewriting one address byte leaves the other three unchanged in the next transfer's `mem_addr`.
- R4: A host write to offset 4 raises `mem_req` one cycle after the strobe, with `mem_we`=1, `mem_wdata` equal to the written byte and `mem_addr` equal to the assembled address. All of these stay steady until the cycle in which `mem_rdy` is high, and `mem_req` drops in the next cycle.
- R5: A host read of offset 4 raises `mem_req` with `mem_we`=0. The byte on `mem_rdata` in the `mem_rdy` cycle appears on `hst_rdata` one cycle later and stays there until the next host read.
- R6: `hst_wait` is high from the cycle after a data-port strobe until the cycle after the `mem_rdy` handshake, and low at all other times. Every data-port access makes exactly one memory transfer.
- R7: Offsets 5 to 7 read as zero, and writes to them change no address byte and start no transfer.
- R8: Host strobes while `hst_wait` is high are ignored. They change no address byte and start no extra transfer. When `hst_wr` and `hst_rd` are both high, the write is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hst_off | input | 3 | Register offset within the window |
| hst_wr | input | 1 | Host write strobe, one cycle |
| hst_rd | input | 1 | Host read strobe, one cycle |
| hst_wdata | input | 8 | Host write byte |
| hst_rdata | output | 8 | Host read byte, valid the cycle after completion |
| hst_wait | output | 1 | Host stall while a memory transfer is open |
| mem_req | output | 1 | Memory transfer request, held until ready |
| mem_we | output | 1 | 1 = write transfer, 0 = read transfer |
| mem_addr | output | 32 | Assembled target address |
| mem_wdata | output | 8 | Byte to store |
| mem_rdata | input | 8 | Byte returned by memory |
| mem_rdy | input | 1 | Memory completes the transfer in this cycle |

## Verification
The bench checks byte order by loading address bytes with distinct values and comparing the address of each transfer. A design with swapped lanes would send requests to mirrored addresses. It rewrites a single middle byte between transfers; a design that cleared or shifted the other bytes would drift off the expected address.

The memory responder stretches `mem_rdy` by random delays, including zero. A request that dropped early, or read data that was latched in the wrong cycle, shows up as a wrong byte or a lost transfer. Strobes are issued while `hst_wait` is high and to offsets above the data port. A design that took either would start a second transfer or corrupt an address byte.

// File: rtl/bw_pkg.sv
package bw_pkg;
  typedef enum logic [0:0] {
    XF_IDLE = 1'b0,
    XF_BUSY = 1'b1
  } xfer_state_e;
endpackage

// File: rtl/bw_addr_bank.sv
module bw_addr_bank #(
  parameter int DATA_W     = 8,
  parameter int ADDR_BYTES = 4,
  parameter int OFF_W      = 3,
  localparam int AW        = DATA_W * ADDR_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [OFF_W-1:0]  wr_off,
  input  logic [DATA_W-1:0] wr_byte,
  output logic [AW-1:0]     addr_q
);
  // one byte lane per address register, little-endian placement
  for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_lane
    logic              lane_en;
    logic [DATA_W-1:0] lane_d;
    logic [DATA_W-1:0] lane_q;

    always_comb begin
      lane_en = wr_en && (wr_off == OFF_W'(g));
      lane_d  = lane_en ? wr_byte : lane_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lane_q <= '0;
      else        lane_q <= lane_d;
    end

    assign addr_q[g*DATA_W +: DATA_W] = lane_q;
  end
endmodule

// File: rtl/bw_xfer_fsm.sv
module bw_xfer_fsm #(
  parameter int DATA_W = 8,
  parameter int AW     = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              start_we,
  input  logic [DATA_W-1:0] start_byte,
  input  logic [AW-1:0]     addr_in,
  output logic              busy,
  output logic              rd_done,
  output logic              mem_req,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_rdy
);
  import bw_pkg::*;

  xfer_state_e       st_q, st_d;
  logic              we_q, we_d;
  logic [DATA_W-1:0] wb_q, wb_d;
  logic              hsk;

  always_comb begin
    hsk  = (st_q == XF_BUSY) && mem_rdy;
    st_d = st_q;
    we_d = we_q;
    wb_d = wb_q;
    case (st_q)
      XF_IDLE: if (start) begin
        st_d = XF_BUSY;
        we_d = start_we;
        wb_d = start_byte;
      end
      XF_BUSY: if (mem_rdy) st_d = XF_IDLE;
      default: st_d = XF_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= XF_IDLE;
      we_q <= 1'b0;
      wb_q <= '0;
    end else begin
      st_q <= st_d;
      we_q <= we_d;
      wb_q <= wb_d;
    end
  end

  assign busy      = (st_q == XF_BUSY);
  assign mem_req   = busy;
  assign mem_we    = we_q;
  assign mem_wdata = wb_q;
  assign mem_addr  = addr_in;
  assign rd_done   = hsk && !we_q;

  // R4
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_rdy |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));
  // R4
  req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_rdy |=> !mem_req);
endmodule

// File: rtl/bw_read_mux.sv
module bw_read_mux #(
  parameter int DATA_W     = 8,
  parameter int ADDR_BYTES = 4,
  parameter int OFF_W      = 3,
  localparam int AW        = DATA_W * ADDR_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_rd,
  input  logic [OFF_W-1:0]  rd_off,
  input  logic [AW-1:0]     addr_q,
  input  logic              mem_done,
  input  logic [DATA_W-1:0] mem_byte,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] sel_byte;
  logic [DATA_W-1:0] rd_d, rd_q;
  logic              rd_en;

  always_comb begin
    sel_byte = '0;
    for (int i = 0; i < ADDR_BYTES; i++) begin
      if (rd_off == OFF_W'(i)) sel_byte = addr_q[i*DATA_W +: DATA_W];
    end
  end

  always_comb begin
    rd_en = mem_done || reg_rd;
    rd_d  = rd_q;
    if (mem_done)    rd_d = mem_byte;
    else if (reg_rd) rd_d = sel_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_q <= '0;
    else if (rd_en) rd_q <= rd_d;
  end

  assign rdata = rd_q;
endmodule

// File: rtl/byte_window_bridge.sv
module byte_window_bridge #(
  parameter int DATA_W     = 8,
  parameter int ADDR_BYTES = 4,
  parameter int OFF_W      = 3,
  localparam int AW        = DATA_W * ADDR_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [OFF_W-1:0]  hst_off,
  input  logic              hst_wr,
  input  logic              hst_rd,
  input  logic [DATA_W-1:0] hst_wdata,
  output logic [DATA_W-1:0] hst_rdata,
  output logic              hst_wait,
  output logic              mem_req,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_rdy
);
  localparam logic [OFF_W-1:0] DATA_OFF = OFF_W'(ADDR_BYTES);

  logic          busy, rd_done;
  logic          accept, is_data, reg_wr, reg_rd, start;
  logic [AW-1:0] addr_q;

  always_comb begin
    accept  = (hst_wr || hst_rd) && !busy;
    is_data = (hst_off == DATA_OFF);
    reg_wr  = accept && hst_wr && (hst_off < DATA_OFF);
    reg_rd  = accept && !hst_wr && hst_rd && !is_data;
    start   = accept && is_data;
  end

  bw_addr_bank #(.DATA_W(DATA_W), .ADDR_BYTES(ADDR_BYTES), .OFF_W(OFF_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .wr_off(hst_off),
    .wr_byte(hst_wdata), .addr_q(addr_q)
  );

  bw_xfer_fsm #(.DATA_W(DATA_W), .AW(AW)) u_xfer (
    .clk(clk), .rst_n(rst_n), .start(start), .start_we(hst_wr),
    .start_byte(hst_wdata), .addr_in(addr_q), .busy(busy), .rd_done(rd_done),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdy(mem_rdy)
  );

  bw_read_mux #(.DATA_W(DATA_W), .ADDR_BYTES(ADDR_BYTES), .OFF_W(OFF_W)) u_rmux (
    .clk(clk), .rst_n(rst_n), .reg_rd(reg_rd), .rd_off(hst_off),
    .addr_q(addr_q), .mem_done(rd_done), .mem_byte(mem_rdata), .rdata(hst_rdata)
  );

  assign hst_wait = busy;

  // R5
  rd_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_rdy && !mem_we |=> hst_rdata == $past(mem_rdata));
  // R6
  wait_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hst_wr || hst_rd) && !hst_wait && hst_off == DATA_OFF |=> hst_wait && mem_req);
  // R7
  hi_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hst_wr && !hst_wait && hst_off > DATA_OFF |=> $stable(mem_addr) && !mem_req);
  // R8
  busy_wr_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hst_wait && hst_wr |=> $stable(mem_addr));
endmodule

// File: tb/sim_byte_window_bridge.sv
module sim_byte_window_bridge;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  hst_off;
  logic        hst_wr, hst_rd;
  logic [7:0]  hst_wdata, hst_rdata;
  logic        hst_wait, mem_req, mem_we, mem_rdy;
  logic [31:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata;

  int n_cmp = 0, n_bad = 0;
  int txn_n = 0;
  int dly   = 0;
  logic [31:0] lg_addr;
  logic        lg_we;
  logic [7:0]  lg_wdata;
  logic [31:0] model;

  always #10 clk = ~clk;

  byte_window_bridge u0 (
    .clk(clk), .rst_n(rst_n), .hst_off(hst_off), .hst_wr(hst_wr), .hst_rd(hst_rd),
    .hst_wdata(hst_wdata), .hst_rdata(hst_rdata), .hst_wait(hst_wait),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_rdy(mem_rdy)
  );

  function automatic logic [7:0] memf(input logic [31:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ a[23:16] ^ (a[31:24] + 8'h5B);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  // memory responder: random latency, logs each completed transfer
  initial begin
    mem_rdy = 1'b0;
    mem_rdata = '0;
    forever begin
      @(negedge clk);
      if (mem_rdy) mem_rdy = 1'b0;
      else if (mem_req) begin
        if (dly == 0) begin
          mem_rdy   = 1'b1;
          mem_rdata = memf(mem_addr);
          lg_addr   = mem_addr;
          lg_we     = mem_we;
          lg_wdata  = mem_wdata;
          txn_n++;
          dly = $urandom % 4;
        end else dly--;
      end
    end
  end

  task automatic host_op(input bit is_wr, input logic [2:0] off, input logic [7:0] val);
    int n0 = txn_n;
    @(negedge clk);
    hst_off = off; hst_wr = is_wr; hst_rd = !is_wr; hst_wdata = val;
    @(negedge clk);
    hst_wr = 1'b0; hst_rd = 1'b0;
    if (off == 3'd4) begin
      chk("R6 wait after data strobe", hst_wait, 1);
      for (int k = 0; k < 50 && hst_wait; k++) @(negedge clk);
      chk("R6 one transfer", txn_n, n0 + 1);
      chk(is_wr ? "R4 addr" : "R5 addr", lg_addr, model);
      chk(is_wr ? "R4 we" : "R5 we", lg_we, is_wr);
      if (is_wr) chk("R4 wdata", lg_wdata, val);
      else       chk("R5 rdata", hst_rdata, memf(model));
    end else begin
      chk("R6 no wait", hst_wait, 0);
      if (!is_wr) chk(off < 3'd4 ? "R2 readback" : "R7 high off reads zero",
                      hst_rdata, off < 3'd4 ? model[off*8 +: 8] : 8'h00);
      else if (off < 3'd4) model[off*8 +: 8] = val;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL R6 watchdog actual=hung expected=done");
    summary();
  end

  initial begin
    int n0;
    void'($urandom(32'd1729));
    rst_n = 1'b0; hst_off = '0; hst_wr = 0; hst_rd = 0; hst_wdata = '0;
    model = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 mem_req", mem_req, 0);
    chk("R1 wait", hst_wait, 0);
    chk("R1 rdata", hst_rdata, 0);
    chk("R1 mem_addr", mem_addr, 0);
    for (int i = 0; i < 4; i++) host_op(0, 3'(i), 0);

    // R2 little-endian byte placement
    host_op(1, 0, 8'h44); host_op(1, 1, 8'h33);
    host_op(1, 2, 8'h22); host_op(1, 3, 8'h11);
    chk("R2 assembled", mem_addr, 32'h11223344);
    host_op(0, 4, 0);
    // R3 partial rewrite keeps other bytes
    host_op(1, 1, 8'h99);
    host_op(0, 4, 0);
    chk("R3 kept bytes", lg_addr, 32'h11229944);
    host_op(1, 4, 8'hC3);
    // R7 high offsets ignore writes
    host_op(1, 5, 8'hFF); host_op(1, 7, 8'hAA);
    chk("R7 addr untouched", mem_addr, 32'h11229944);
    chk("R7 no transfer", mem_req, 0);
    host_op(0, 6, 0);

    // R8 strobes during a stall are ignored
    dly = 5;
    n0 = txn_n;
    @(negedge clk); hst_off = 4; hst_wr = 1; hst_wdata = 8'h5E;
    @(negedge clk); hst_wr = 0;
    @(negedge clk); hst_off = 0; hst_wr = 1; hst_wdata = 8'hEE;
    @(negedge clk); hst_off = 4; hst_wr = 0; hst_rd = 1;
    @(negedge clk); hst_rd = 0;
    for (int k = 0; k < 50 && hst_wait; k++) @(negedge clk);
    repeat (3) @(negedge clk);
    chk("R8 single transfer", txn_n, n0 + 1);
    chk("R8 wdata kept", lg_wdata, 8'h5E);
    host_op(0, 0, 0);
    // R8 both strobes: write wins
    @(negedge clk); hst_off = 2; hst_wr = 1; hst_rd = 1; hst_wdata = 8'h7D;
    @(negedge clk); hst_wr = 0; hst_rd = 0;
    model[23:16] = 8'h7D;
    chk("R8 write wins", mem_addr, model);

    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [2:0] o = 3'($urandom % 8);
      host_op(1'($urandom % 2), o, 8'($urandom));
    end
    chk("R3 final addr", mem_addr, model);
    summary();
  end
endmodule